// File: doc/BRIEF.md
# Tachometer Period-to-RPM Meter

The block measures the rotational speed of a fan from its tachometer line. It times one full tachometer period by counting reference ticks between two successive rising edges, then converts that period into revolutions per minute with a serial divider. The tachometer delivers two pulses per revolution and the reference ticks run at 120 kHz, so the result is 3,600,000 divided by the tick count.

Each measurement runs under a request/acknowledge exchange with an external voter. The voter pulses a start request. The block clears its previous result and waits for a tachometer edge to begin timing. When the result is ready, the block raises a ready flag and holds the value until the next request. If the fan is stopped or too slow to time, the period counter saturates. The block then reports zero speed and still signals ready, so the voter is never left waiting.

Top module: `tach_rpm_meter`

## Requirements
- R1: After reset, ready_o is 0 and rpm_o is 0.
- R2: A go_i pulse seen while the block is idle or holding a result clears ready_o and rpm_o to 0 on the next clock. A go_i pulse during an ongoing measurement or conversion is ignored, and the ongoing result is still delivered.
- R3: tach_i passes through a two-stage synchroniser and only its rising edges are used. The first rising edge after an accepted go_i restarts the period count at zero. The next rising edge closes the measurement.
- R4: The captured count is the number of clock cycles with tick_i high after the opening edge, up to and including the cycle of the closing edge. rpm_o is floor(3,600,000 / count), which is 60 × 120,000 / (2 × count).
- R5: The conversion takes one clock per result bit (22 with the defaults). ready_o rises between 22 and 30 clock cycles after the rising tach_i edge that closes the measurement.
- R6: If the count reaches 2^CNT_W−1 (4095 with the defaults) before a measurement closes, the block sets rpm_o to 0 and ready_o to 1. This covers the case where no edge arrives after go_i. A period of exactly 4095 ticks therefore reports 0, and a period of 4094 ticks reports 879.
- R7: Once ready_o is 1, ready_o and rpm_o stay unchanged until the next go_i.
- R8: The period count advances only in cycles where tick_i is 1. With one tick every third clock, a 30-clock period reports 360,000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Reference tick enable, synchronous to clk_i |
| tach_i | input | 1 | Asynchronous tachometer pulse line |
| go_i | input | 1 | Start-measurement request, one-clock pulse |
| rpm_o | output | 22 | Speed result in RPM, 0 while not ready |
| ready_o | output | 1 | Result valid, held until the next go_i |

## Verification
The assertions assume the following about the inputs:
- go_i and tick_i are synchronous to clk_i.
- Every tachometer high and low phase lasts several clocks, so the synchroniser sees each edge exactly once.

The bench drives every input on the falling clock edge. It keeps each tachometer phase at four clocks or more. It issues go_i only after a fresh tachometer edge has been seen, so the opening edge always belongs to a full period of the programmed length. Tick patterns are used only with periods that are whole multiples of the tick spacing, so every window holds a known number of ticks. Under these conditions the assertions check the following:
- go_i clears a held result.
- rpm_o is zero whenever ready_o is low.
- A held result never changes.
- rpm_o never exceeds the full-scale constant.

// File: rtl/tach_rpm_pkg.sv
package tach_rpm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_MEAS,
    ST_DIV,
    ST_DONE
  } meas_state_e;

endpackage

// File: rtl/tach_edge_sync.sv
module tach_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/tach_period_counter.sv
module tach_period_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_next_o,
  output logic             sat_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  // value including this cycle's tick, used for capture
  always_comb begin
    cnt_next_o = cnt_q;
    if (tick_i && (cnt_q != CNT_MAX)) cnt_next_o = cnt_q + 1'b1;
  end

  assign sat_o = (cnt_next_o == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (run_i)   cnt_q <= cnt_next_o;
  end

endmodule

// File: rtl/rpm_serial_divider.sv
module rpm_serial_divider #(
  parameter int          NUM_W    = 22,
  parameter int          DEN_W    = 12,
  parameter int unsigned DIVIDEND = 3600000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quot_o
);

  localparam int               STEP_W = $clog2(NUM_W + 1);
  localparam logic [NUM_W-1:0] DVD    = NUM_W'(DIVIDEND);

  logic [DEN_W-1:0]  rem_q;
  logic [NUM_W-1:0]  quo_q;
  logic [DEN_W-1:0]  den_q;
  logic [STEP_W-1:0] steps_q;
  logic              done_q;

  logic [DEN_W:0] trial;
  logic [DEN_W:0] diff;
  logic           fits;

  always_comb begin
    trial = {rem_q, quo_q[NUM_W-1]};
    fits  = (trial >= {1'b0, den_q});
    diff  = trial - {1'b0, den_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q   <= '0;
      quo_q   <= '0;
      den_q   <= '0;
      steps_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        rem_q   <= '0;
        quo_q   <= DVD;
        den_q   <= den_i;
        steps_q <= STEP_W'(NUM_W);
      end else if (steps_q != '0) begin
        rem_q   <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        quo_q   <= {quo_q[NUM_W-2:0], fits};
        steps_q <= steps_q - 1'b1;
        if (steps_q == STEP_W'(1)) done_q <= 1'b1;
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = quo_q;

endmodule

// File: rtl/tach_rpm_meter.sv
module tach_rpm_meter
  import tach_rpm_pkg::*;
#(
  parameter int CNT_W          = 12,
  parameter int REF_HZ         = 120000,
  parameter int PULSES_PER_REV = 2,
  parameter int SYNC_STAGES    = 2
) (
  input  logic                                         clk_i,
  input  logic                                         rst_ni,
  input  logic                                         tick_i,
  input  logic                                         tach_i,
  input  logic                                         go_i,
  output logic [$clog2(60*REF_HZ/PULSES_PER_REV+1)-1:0] rpm_o,
  output logic                                         ready_o
);

  localparam int unsigned RPM_NUM = 60 * REF_HZ / PULSES_PER_REV;
  localparam int          RPM_W   = $clog2(RPM_NUM + 1);

  meas_state_e      state_q;
  logic             ready_q;
  logic [RPM_W-1:0] rpm_q;

  logic             rise;
  logic [CNT_W-1:0] cnt_next;
  logic             sat;
  logic             cnt_clear;
  logic             cnt_run;
  logic             accept_go;
  logic             div_start;
  logic             div_done;
  logic [RPM_W-1:0] quot;

  tach_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(tach_i),
    .rise_o (rise)
  );

  tach_period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (cnt_clear),
    .run_i     (cnt_run),
    .tick_i    (tick_i),
    .cnt_next_o(cnt_next),
    .sat_o     (sat)
  );

  rpm_serial_divider #(
    .NUM_W   (RPM_W),
    .DEN_W   (CNT_W),
    .DIVIDEND(RPM_NUM)
  ) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(div_start),
    .den_i  (cnt_next),
    .done_o (div_done),
    .quot_o (quot)
  );

  always_comb begin
    accept_go = go_i && ((state_q == ST_IDLE) || (state_q == ST_DONE));
    cnt_run   = (state_q == ST_ARM) || (state_q == ST_MEAS);
    cnt_clear = accept_go || ((state_q == ST_ARM) && rise && !sat);
    div_start = (state_q == ST_MEAS) && rise && !sat && (cnt_next != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ready_q <= 1'b0;
      rpm_q   <= '0;
    end else if (accept_go) begin
      state_q <= ST_ARM;
      ready_q <= 1'b0;
      rpm_q   <= '0;
    end else begin
      unique case (state_q)
        ST_ARM: begin
          if (sat) begin
            state_q <= ST_DONE;
            ready_q <= 1'b1;
          end else if (rise) begin
            state_q <= ST_MEAS;
          end
        end
        ST_MEAS: begin
          if (sat) begin
            state_q <= ST_DONE;
            ready_q <= 1'b1;
          end else if (rise) begin
            if (cnt_next == '0) begin
              state_q <= ST_DONE;
              ready_q <= 1'b1;
            end else begin
              state_q <= ST_DIV;
            end
          end
        end
        ST_DIV: begin
          if (div_done) begin
            state_q <= ST_DONE;
            ready_q <= 1'b1;
            rpm_q   <= quot;
          end
        end
        default: ;
      endcase
    end
  end

  assign rpm_o   = rpm_q;
  assign ready_o = ready_q;

endmodule

// File: rtl/tach_rpm_meter_chk.sv
module tach_rpm_meter_chk #(
  parameter int          RPM_W   = 22,
  parameter int unsigned RPM_NUM = 3600000
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             go_i,
  input logic             ready_o,
  input logic [RPM_W-1:0] rpm_o
);

  // R2: go on a held result clears it next cycle
  a_r2_go_clears_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_i && ready_o) |=> (!ready_o && (rpm_o == '0)));

  // R2: no stale value is visible while busy
  a_r2_rpm_zero_when_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (rpm_o == '0));

  // R7: result held until next go
  a_r7_ready_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !go_i) |=> ready_o);

  a_r7_rpm_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !go_i) |=> $stable(rpm_o));

  // R4: quotient never above full scale
  a_r4_rpm_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(rpm_o) <= RPM_NUM);

endmodule

bind tach_rpm_meter tach_rpm_meter_chk #(
  .RPM_W  (RPM_W),
  .RPM_NUM(RPM_NUM)
) u_chk (.*);

// File: tb/tb_tach_rpm_meter.sv
module tb_tach_rpm_meter;

  localparam int          RPM_W   = 22;
  localparam int unsigned FULL    = 60 * 120000 / 2;
  localparam int          CNT_MAX = 4095;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             tick_i = 1'b1;
  logic             tach_i = 1'b0;
  logic             go_i = 1'b0;
  logic [RPM_W-1:0] rpm_o;
  logic             ready_o;

  int   n_checks = 0;
  int   n_errors = 0;
  int   tach_period = 40;
  bit   tach_en = 1'b0;
  int   tick_div = 1;
  int   tick_ctr = 0;
  int   gen_p;
  event rise_ev;

  tach_rpm_meter dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .tach_i (tach_i),
    .go_i   (go_i),
    .rpm_o  (rpm_o),
    .ready_o(ready_o)
  );

  always #10 clk_i = ~clk_i;

  always @(negedge clk_i) begin
    tick_i   <= ((tick_ctr % tick_div) == 0);
    tick_ctr <= tick_ctr + 1;
  end

  always begin
    @(negedge clk_i);
    if (tach_en) begin
      gen_p  = tach_period;
      tach_i = 1'b1;
      -> rise_ev;
      repeat (gen_p / 2) @(negedge clk_i);
      tach_i = 1'b0;
      repeat (gen_p - gen_p / 2 - 1) @(negedge clk_i);
    end else begin
      tach_i = 1'b0;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint expect_rpm(input int per, input int kdiv);
    int cnt = per / kdiv;
    if (cnt >= CNT_MAX) return 0;
    return longint'(FULL / cnt);
  endfunction

  task automatic pulse_go();
    @(negedge clk_i) go_i = 1'b1;
    @(negedge clk_i) go_i = 1'b0;
  endtask

  task automatic set_period(input int per);
    tach_period = per;
    tach_en = 1'b1;
    @(rise_ev);
    repeat (4) @(negedge clk_i);
  endtask

  task automatic wait_ready(input int limit, output bit got);
    got = 1'b0;
    for (int i = 0; i < limit; i++) begin
      if (ready_o) begin
        got = 1'b1;
        break;
      end
      @(negedge clk_i);
    end
  endtask

  task automatic measure(input int per, input string tag);
    bit got;
    longint exp;
    set_period(per);
    pulse_go();
    check(!ready_o && rpm_o == 0, "R2 go clears result", longint'(rpm_o) + (ready_o ? 1000000000 : 0), 0);
    wait_ready(3 * per + 6000, got);
    check(got, {tag, " ready arrives"}, got, 1);
    exp = expect_rpm(per, tick_div);
    check(longint'(rpm_o) == exp, tag, rpm_o, exp);
  endtask

  initial begin
    bit got;
    int lat;
    repeat (3) @(negedge clk_i);
    check(!ready_o && rpm_o == 0, "R1 reset state", rpm_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(!ready_o && rpm_o == 0, "R1 after release", ready_o, 0);

    // R3 R4 sweep over periods
    for (int p = 8; p <= 160; p++) measure(p, "R4 period sweep");

    // R7 hold
    repeat (50) @(negedge clk_i);
    check(ready_o == 1'b1, "R7 ready held", ready_o, 1);
    check(longint'(rpm_o) == expect_rpm(160, 1), "R7 rpm held", rpm_o, expect_rpm(160, 1));

    // R2 ignored go during conversion, R5 latency
    set_period(100);
    pulse_go();
    @(rise_ev);
    @(rise_ev);
    lat = 0;
    for (int i = 0; i < 40; i++) begin
      if (i == 8) go_i = 1'b1;
      if (i == 9) go_i = 1'b0;
      @(negedge clk_i);
      lat++;
      if (ready_o) break;
    end
    check(ready_o && lat >= 22 && lat <= 30, "R5 conversion latency", lat, 26);
    check(longint'(rpm_o) == 36000, "R2 go ignored while busy", rpm_o, 36000);

    // R8 tick gating
    tick_div = 3;
    measure(30, "R8 tick every third clock");
    measure(60, "R8 tick every third clock");
    measure(300, "R8 tick every third clock");
    tick_div = 1;
    repeat (4) @(negedge clk_i);

    // R6 saturation boundaries
    measure(4094, "R6 longest measurable period");
    measure(4095, "R6 period at saturation");
    measure(5000, "R6 period beyond saturation");
    measure(8, "R4 recovery after timeout");

    // R6 stopped fan
    tach_en = 1'b0;
    repeat (10) @(negedge clk_i);
    pulse_go();
    wait_ready(6000, got);
    check(got, "R6 stopped fan ready", got, 1);
    check(rpm_o == 0, "R6 stopped fan rpm", rpm_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    n_errors++;
    $display("FAIL watchdog R5: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule